// File: doc/BRIEF.md
# Shared-Register Floating-Point Operand Fetch

This block gathers the floating-point source operands of an instruction on a core that keeps floating-point values in its 32-bit integer register file and has no separate floating-point registers. Each instruction presents up to three register specifiers, a per-port enable and one format code (half, single or double precision). For every source port the block drives two read addresses into the integer register file, receives the two words, and produces a 64-bit operand together with an illegal-instruction flag. All results are registered, so they appear one cycle after the specifiers.

A double-precision operand does not fit in one 32-bit register. It is built from an even/odd register pair, and an odd specifier is rejected. A single input bit selects the byte order of the pair. In little-endian order the even register holds the low half. In big-endian order the even register holds the high half. A double source at specifier 0 always reads as zero, whatever register 1 holds. Half and single sources come from the low bits of one register and are zero-extended to 64 bits. The upper register bits are never tested for a NaN box. A per-port illegal flag is produced, and also the OR of all ports, which the issue stage can use to raise one exception.

Top module: `fpx_operand_fetch`

## Requirements
- R1: Every operand, every illegal flag and the combined flag are zero while reset is held, and each reflects the inputs one clock cycle after they are presented.
- R2: For each port, read address P equals the specifier and read address S equals the specifier with bit 0 forced to 1. Both addresses are combinational from the inputs. Specifier i occupies bits [5i+4:5i].
- R3: With format 2'b10 (double), an even nonzero specifier and the byte-order bit low, the operand is {word at S, word at P}. The operand of port i occupies bits [64i+63:64i].
- R4: With format 2'b10, an even nonzero specifier and the byte-order bit high, the operand is {word at P, word at S}.
- R5: With format 2'b10 and specifier 0, the operand is 64 zero bits and the port is legal, whatever register 1 holds.
- R6: With format 2'b10 and an odd specifier, the port's illegal flag is 1 and its operand is zero.
- R7: With format 2'b01 (single), the operand is bits [31:0] of the word at P, zero-extended. The port is never illegal.
- R8: With format 2'b00 (half), the operand is bits [15:0] of the word at P, zero-extended. Bits [31:16] of the register have no effect and the port is never illegal.
- R9: Format 2'b11 is reserved. It makes every enabled port illegal, with a zero operand.
- R10: A port whose enable is 0 has a zero operand and a clear illegal flag, whatever its specifier and the format.
- R11: The combined illegal output is the OR of the three per-port flags, and is valid in the same cycle as them.
- R12: The byte-order bit is taken in the same cycle as the specifiers. It has no effect on half or single operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 3 | Per-port enable |
| src_fmt | input | 2 | Format: 00 half, 01 single, 10 double, 11 reserved |
| big_endian | input | 1 | Pair byte order: 1 means the even register holds the high half |
| src_spec | input | 15 | Three 5-bit register specifiers |
| rf_raddr_p | output | 15 | Primary read address per port (the specifier) |
| rf_raddr_s | output | 15 | Secondary read address per port (specifier with bit 0 set) |
| rf_rdata_p | input | 96 | Register word at each primary address |
| rf_rdata_s | input | 96 | Register word at each secondary address |
| opnd | output | 192 | Three 64-bit assembled operands |
| opnd_illegal | output | 3 | Per-port illegal-instruction flag |
| any_illegal | output | 1 | OR of the per-port flags |

## Verification
The assertions check on every cycle that an odd double specifier gives an illegal flag, that a double at specifier 0 gives zero, that a disabled port stays silent, and that both pair orders and the single-precision extraction follow the words read one cycle earlier. The bench is the only check that the half-precision path ignores the upper register bits and that the byte-order bit has no effect on narrow formats. It also checks that the combined flag follows the per-port flags and that the read addresses are correct. It does this with a randomly filled register file in which register 1 holds a nonzero value, and with a random mix of formats, enables and byte orders.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    typedef enum logic [1:0] {
        FMT_HALF   = 2'b00,
        FMT_SINGLE = 2'b01,
        FMT_DOUBLE = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;
endpackage

// File: rtl/fpx_spec_check.sv
module fpx_spec_check #(
    parameter int AW = 5
) (
    input  logic          en,
    input  fpx_pkg::fmt_e fmt,
    input  logic [AW-1:0] spec,
    output logic          illegal,
    output logic          pair_zero
);
    import fpx_pkg::*;

    always_comb begin
        illegal   = 1'b0;
        pair_zero = 1'b0;
        if (en) begin
            if (fmt == FMT_RSVD) begin
                illegal = 1'b1;
            end else if (fmt == FMT_DOUBLE) begin
                illegal   = spec[0];
                pair_zero = (spec == '0);
            end
        end
    end
endmodule

// File: rtl/fpx_pair_assemble.sv
module fpx_pair_assemble #(
    parameter int XLEN   = 32,
    parameter int FLEN   = 64,
    parameter int HALF_W = 16,
    parameter int SGL_W  = 32
) (
    input  fpx_pkg::fmt_e   fmt,
    input  logic            big_endian,
    input  logic            pair_zero,
    input  logic [XLEN-1:0] word_p,
    input  logic [XLEN-1:0] word_s,
    output logic [FLEN-1:0] value
);
    import fpx_pkg::*;

    always_comb begin
        unique case (fmt)
            FMT_HALF:   value = FLEN'(word_p[HALF_W-1:0]);
            FMT_SINGLE: value = FLEN'(word_p[SGL_W-1:0]);
            FMT_DOUBLE: begin
                if (pair_zero)       value = '0;
                else if (big_endian) value = {word_p, word_s};
                else                 value = {word_s, word_p};
            end
            default:    value = '0;
        endcase
    end
endmodule

// File: rtl/fpx_operand_fetch.sv
module fpx_operand_fetch #(
    parameter int NUM_SRC = 3,
    parameter int XLEN    = 32,
    parameter int AW      = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      src_en,
    input  logic [1:0]              src_fmt,
    input  logic                    big_endian,
    input  logic [NUM_SRC*AW-1:0]   src_spec,
    output logic [NUM_SRC*AW-1:0]   rf_raddr_p,
    output logic [NUM_SRC*AW-1:0]   rf_raddr_s,
    input  logic [NUM_SRC*XLEN-1:0] rf_rdata_p,
    input  logic [NUM_SRC*XLEN-1:0] rf_rdata_s,
    output logic [NUM_SRC*2*XLEN-1:0] opnd,
    output logic [NUM_SRC-1:0]      opnd_illegal,
    output logic                    any_illegal
);
    import fpx_pkg::*;

    localparam int FLEN = 2 * XLEN;

    typedef struct packed {
        logic [NUM_SRC*FLEN-1:0] opnd;
        logic [NUM_SRC-1:0]      ill;
        logic                    any;
    } state_t;

    state_t st_d, st_q;
    fmt_e   fmt_w;
    logic [NUM_SRC-1:0] ill_w;
    logic [FLEN-1:0]    val_w [NUM_SRC];

    assign fmt_w = fmt_e'(src_fmt);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_port
        logic [AW-1:0] spec_i;
        logic          zero_i;

        assign spec_i = src_spec[i*AW +: AW];
        assign rf_raddr_p[i*AW +: AW] = spec_i;
        assign rf_raddr_s[i*AW +: AW] = {spec_i[AW-1:1], 1'b1};

        fpx_spec_check #(.AW(AW)) i_check (
            .en        (src_en[i]),
            .fmt       (fmt_w),
            .spec      (spec_i),
            .illegal   (ill_w[i]),
            .pair_zero (zero_i)
        );

        fpx_pair_assemble #(.XLEN(XLEN), .FLEN(FLEN)) i_asm (
            .fmt        (fmt_w),
            .big_endian (big_endian),
            .pair_zero  (zero_i),
            .word_p     (rf_rdata_p[i*XLEN +: XLEN]),
            .word_s     (rf_rdata_s[i*XLEN +: XLEN]),
            .value      (val_w[i])
        );

        // R6: an odd double specifier is flagged and its operand cleared
        a_r6_odd_double: assert property (@(posedge clk) disable iff (!rst_n)
            (src_en[i] && src_fmt == 2'b10 && spec_i[0])
            |=> (opnd_illegal[i] && opnd[i*FLEN +: FLEN] == '0));

        // R5: a double at specifier 0 reads as zero
        a_r5_x0_pair: assert property (@(posedge clk) disable iff (!rst_n)
            (src_en[i] && src_fmt == 2'b10 && spec_i == '0)
            |=> (!opnd_illegal[i] && opnd[i*FLEN +: FLEN] == '0));

        // R10: a disabled port stays silent
        a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            !src_en[i] |=> (!opnd_illegal[i] && opnd[i*FLEN +: FLEN] == '0));

        // R3: little-endian pair order
        a_r3_le_pair: assert property (@(posedge clk) disable iff (!rst_n)
            (src_en[i] && src_fmt == 2'b10 && !spec_i[0] && spec_i != '0 && !big_endian)
            |=> (opnd[i*FLEN +: FLEN] == {$past(rf_rdata_s[i*XLEN +: XLEN]),
                                          $past(rf_rdata_p[i*XLEN +: XLEN])}));

        // R4: big-endian pair order
        a_r4_be_pair: assert property (@(posedge clk) disable iff (!rst_n)
            (src_en[i] && src_fmt == 2'b10 && !spec_i[0] && spec_i != '0 && big_endian)
            |=> (opnd[i*FLEN +: FLEN] == {$past(rf_rdata_p[i*XLEN +: XLEN]),
                                          $past(rf_rdata_s[i*XLEN +: XLEN])}));

        // R7: single precision takes the low word, zero-extended, never illegal
        a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
            (src_en[i] && src_fmt == 2'b01)
            |=> (!opnd_illegal[i] &&
                 opnd[i*FLEN +: FLEN] == {{XLEN{1'b0}}, $past(rf_rdata_p[i*XLEN +: XLEN])}));
    end

    always_comb begin
        st_d = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            st_d.ill[i] = ill_w[i];
            if (src_en[i] && !ill_w[i]) begin
                st_d.opnd[i*FLEN +: FLEN] = val_w[i];
            end
        end
        st_d.any = |ill_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign opnd         = st_q.opnd;
    assign opnd_illegal = st_q.ill;
    assign any_illegal  = st_q.any;

    // R9: the reserved format makes every enabled port illegal
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (src_fmt == 2'b11 && src_en != '0) |=> any_illegal);
endmodule

// File: tb/test_fpx_operand_fetch.sv
module test_fpx_operand_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_en = '0;
    logic [1:0]    src_fmt = 2'b00;
    logic          big_endian = 1'b0;
    logic [NS*5-1:0]  src_spec = '0;
    logic [NS*5-1:0]  rf_raddr_p, rf_raddr_s;
    logic [NS*32-1:0] rf_rdata_p, rf_rdata_s;
    logic [NS*64-1:0] opnd;
    logic [NS-1:0]    opnd_illegal;
    logic             any_illegal;

    logic [31:0] rf [32];
    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [63:0] exp_v [NS];
    logic        exp_i [NS];
    string       exp_t [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar i = 0; i < NS; i++) begin : g_rf
        assign rf_rdata_p[i*32 +: 32] = rf[rf_raddr_p[i*5 +: 5]];
        assign rf_rdata_s[i*32 +: 32] = rf[rf_raddr_s[i*5 +: 5]];
    end

    fpx_operand_fetch i_fpx_operand_fetch (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_fmt(src_fmt),
        .big_endian(big_endian), .src_spec(src_spec),
        .rf_raddr_p(rf_raddr_p), .rf_raddr_s(rf_raddr_s),
        .rf_rdata_p(rf_rdata_p), .rf_rdata_s(rf_rdata_s),
        .opnd(opnd), .opnd_illegal(opnd_illegal), .any_illegal(any_illegal)
    );

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Reference: behaviour written from the requirements
    task automatic model(input logic [4:0] s, input logic [1:0] f, input logic e,
                         input logic b, output logic [63:0] v, output logic il,
                         output string tag);
        logic [31:0] even_w, odd_w;
        v = '0; il = 1'b0;
        even_w = rf[{s[4:1], 1'b0}];
        odd_w  = rf[{s[4:1], 1'b1}];
        if (!e) tag = "R10";
        else if (f == 2'b11) begin il = 1'b1; tag = "R9"; end
        else if (f == 2'b00) begin v = {48'h0, rf[s][15:0]}; tag = b ? "R12/R8" : "R8"; end
        else if (f == 2'b01) begin v = {32'h0, rf[s]}; tag = b ? "R12/R7" : "R7"; end
        else if (s[0]) begin il = 1'b1; tag = "R6"; end
        else if (s == 5'd0) tag = "R5";
        else if (b) begin v = {even_w, odd_w}; tag = "R4"; end
        else begin v = {odd_w, even_w}; tag = "R3"; end
    endtask

    task automatic compare_outputs();
        logic any_exp;
        any_exp = 1'b0;
        for (int i = 0; i < NS; i++) begin
            check64({exp_t[i], " operand"}, opnd[i*64 +: 64], exp_v[i]);
            check64({exp_t[i], " illegal"}, 64'(opnd_illegal[i]), 64'(exp_i[i]));
            any_exp |= exp_i[i];
        end
        check64("R11 combined", 64'(any_illegal), 64'(any_exp));
    endtask

    task automatic step(input logic [14:0] s, input logic [1:0] f,
                        input logic [2:0] e, input logic b);
        @(negedge clk);
        src_spec = s; src_fmt = f; src_en = e; big_endian = b;
        #1;
        for (int i = 0; i < NS; i++) begin
            check64("R2 addr P", 64'(rf_raddr_p[i*5 +: 5]), 64'(s[i*5 +: 5]));
            check64("R2 addr S", 64'(rf_raddr_s[i*5 +: 5]), 64'({s[i*5+1 +: 4], 1'b1}));
            model(s[i*5 +: 5], f, e[i], b, exp_v[i], exp_i[i], exp_t[i]);
        end
        @(negedge clk);
        compare_outputs();
    endtask

    function automatic logic [14:0] sp(int a, int b, int c);
        return {5'(c), 5'(b), 5'(a)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 32; r++) rf[r] = (r == 0) ? 32'h0 : $urandom;
        rf[1] = 32'hDEAD_BEEF;
        rf[5] = 32'h1234_ABCD;
        src_en = 3'b111; src_fmt = 2'b10; src_spec = sp(2, 4, 6);
        repeat (3) @(negedge clk);
        // R1: reset state with active inputs
        check64("R1 reset operands", opnd[63:0] | opnd[127:64] | opnd[191:128], 64'h0);
        check64("R1 reset flags", 64'({opnd_illegal, any_illegal}), 64'h0);
        rst_n = 1'b1;
        step(sp(2, 4, 30), 2'b10, 3'b111, 1'b0); // R3
        step(sp(2, 4, 30), 2'b10, 3'b111, 1'b1); // R4
        step(sp(0, 8, 0), 2'b10, 3'b111, 1'b0);  // R5, register 1 nonzero
        step(sp(0, 1, 0), 2'b10, 3'b111, 1'b1);  // R5 big-endian
        step(sp(3, 4, 31), 2'b10, 3'b111, 1'b0); // R6
        step(sp(5, 1, 7), 2'b01, 3'b111, 1'b0);  // R7
        step(sp(5, 1, 7), 2'b01, 3'b111, 1'b1);  // R12 single
        step(sp(5, 1, 7), 2'b00, 3'b111, 1'b0);  // R8
        step(sp(5, 1, 7), 2'b00, 3'b111, 1'b1);  // R12 half
        step(sp(2, 4, 6), 2'b11, 3'b011, 1'b0);  // R9, port 2 disabled
        step(sp(3, 5, 7), 2'b10, 3'b000, 1'b0);  // R10 odd specifiers off
        step(sp(2, 4, 9), 2'b10, 3'b011, 1'b0);  // R10 third port unchecked
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            rf[1 + ($urandom % 31)] = $urandom;
            step(15'($urandom), 2'($urandom), 3'($urandom), 1'($urandom));
        end
        // R1: reset clears registered state again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check64("R1 re-reset", 64'({opnd_illegal, any_illegal}) | opnd[63:0], 64'h0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule